// File: doc/BRIEF.md
# Port Power and Overcurrent Controller

This block manages the power switches of the two downstream ports of a hub. Each switch enable is active low and open-drain. The block models each one as an output enable, so a 1 on `pwr_oe[i]` means the pad is pulled low and VBUS on port i is switched on. Hub logic asks for power with one-cycle set and clear pulses for each port. The block holds the resulting power state and removes power on its own when a filtered overcurrent is accepted.

After reset is released, the power-enable pin that carries the mode strap is still an input for a fixed window. At the end of that window the block latches the pin level: high selects individual control and low selects gang control. Until then no enable output is driven and power requests are ignored. In gang mode the two ports act as one: a request on either port powers or unpowers both, and an overcurrent on either port cuts both. Overcurrent inputs are active low and asynchronous. They pass through a two-flop synchroniser and a consecutive-cycle filter, and the result is reported as a level status and a sticky change flag per port. Software clears each change flag with a write-one-to-clear pulse.

There is no data stream, so every pin is a plain control or status signal.

Top module: `port_power_ctl`

## Requirements
- R1: After `rst_n` goes high, `strap_done` rises after exactly STRAP_CYCLES (default 72) rising clock edges. At that edge `gang_mode` takes the inverse of `strap_pad_in` (pad high = individual = 0, pad low = gang = 1). Both stay fixed until the next reset.
- R2: While `strap_done` is 0, `pwr_oe` is 0 for every port and set pulses are ignored, so both ports are still unpowered once the window ends.
- R3: During reset, `pwr_oe`, `port_powered`, `oc_status`, `oc_change`, `gang_mode` and `strap_done` are all 0.
- R4: `pwr_oe[i]` equals `port_powered[i]` once `strap_done` is 1. A value of 1 drives the pad low, which switches VBUS on.
- R5: In individual mode, a `pwr_set[i]` pulse powers port i and a `pwr_clr[i]` pulse unpowers it. The new state appears one cycle after the pulse, clear wins over set, and the other port is unaffected.
- R6: In gang mode, a set pulse on any port powers both ports and a clear pulse on any port unpowers both. Clear wins over set.
- R7: A low on `oc_n[i]` is accepted only after the two-flop synchroniser, once it has been seen low on 8 consecutive cycles. A low held for 8 input cycles sets the port's status 10 edges after it is applied. A low held for 7 cycles is never accepted. After the input returns high, the status clears on the 3rd edge.
- R8: In individual mode, an accepted overcurrent on port i unpowers only port i and sets only `oc_change[i]`, one edge after `oc_status[i]` rises.
- R9: In gang mode, an accepted overcurrent on either port unpowers both ports and sets both `oc_status` bits and both `oc_change` bits.
- R10: A set pulse is ignored while the overcurrent status that governs it is 1 (the port's own status in individual mode, either status in gang mode).
- R11: `oc_change[i]` stays 1 until an `oc_ack[i]` pulse clears it. An ack on the other bit leaves it unchanged, and a new event in the same cycle as an ack wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (24 MHz nominal) |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_pad_in | input | 1 | Level read back from the power-enable pin that carries the mode strap |
| pwr_set | input | 2 | One-cycle power-on request per port |
| pwr_clr | input | 2 | One-cycle power-off request per port |
| oc_n | input | 2 | Asynchronous active-low overcurrent flag per port |
| oc_ack | input | 2 | Write-one-to-clear pulse for the change flags |
| pwr_oe | output | 2 | Open-drain enable; 1 pulls the pad low (VBUS on) |
| port_powered | output | 2 | Current power state per port |
| oc_status | output | 2 | Accepted overcurrent level per port |
| oc_change | output | 2 | Sticky overcurrent event flag per port |
| gang_mode | output | 1 | Latched mode: 1 = gang, 0 = individual |
| strap_done | output | 1 | Strap window has ended and outputs may drive |

## Verification
The assertions assume that set, clear and ack arrive as pulses sampled on single edges, and that the strap pin level is steady for the whole window after reset. The bench drives every request as a one-cycle pulse at the falling edge. It holds the strap level from before reset release until the window closes, and it changes the overcurrent inputs only at falling edges. The random phases keep overcurrent high so that the power model stays exact. Overcurrent filtering, the glitch case and the mode-dependent cut-off are covered by directed sequences whose timing is counted edge by edge.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  typedef enum logic {
    PWR_MODE_INDIV = 1'b0,
    PWR_MODE_GANG  = 1'b1
  } pwr_mode_e;

  // Pad high means individual control, pad low means gang control.
  function automatic pwr_mode_e mode_from_pad(input logic pad_level);
    return pad_level ? PWR_MODE_INDIV : PWR_MODE_GANG;
  endfunction
endpackage

// File: rtl/ppc_strap_latch.sv
module ppc_strap_latch
  import ppc_pkg::*;
#(
  parameter int STRAP_CYCLES = 72
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pad_level_i,
  output logic      done_o,
  output pwr_mode_e mode_o
);
  localparam int CW = $clog2(STRAP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STRAP_CYCLES - 1);

  logic [CW-1:0] win_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt_q <= '0;
      done_o    <= 1'b0;
      mode_o    <= PWR_MODE_INDIV;
    end else if (!done_o) begin
      if (win_cnt_q == LAST) begin
        done_o <= 1'b1;
        mode_o <= mode_from_pad(pad_level_i);
      end else begin
        win_cnt_q <= win_cnt_q + 1'b1;
      end
    end
  end

  // R1: once the window has closed the latched mode never moves
  a_r1_strap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && $stable(mode_o)));
endmodule

// File: rtl/ppc_oc_filter.sv
module ppc_oc_filter #(
  parameter int FILT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_n_async_i,
  output logic active_o,
  output logic rise_o
);
  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam logic [FW-1:0] LAST = FW'(FILT_CYCLES - 1);

  logic [1:0]    sync_q;
  logic [FW-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
    end else begin
      sync_q <= {sync_q[0], oc_n_async_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      active_o  <= 1'b0;
      rise_o    <= 1'b0;
    end else if (sync_q[1]) begin
      low_cnt_q <= '0;
      active_o  <= 1'b0;
      rise_o    <= 1'b0;
    end else if (active_o) begin
      rise_o <= 1'b0;
    end else if (low_cnt_q == LAST) begin
      active_o <= 1'b1;
      rise_o   <= 1'b1;
    end else begin
      low_cnt_q <= low_cnt_q + 1'b1;
      rise_o    <= 1'b0;
    end
  end

  // R7: a synchronised high level always withdraws acceptance next cycle
  a_r7_release_drops: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q[1] |=> !active_o);

  // R7: the event pulse lasts one cycle only
  a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ppc_power_ctrl.sv
module ppc_power_ctrl
  import ppc_pkg::*;
#(
  parameter int NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable_i,
  input  pwr_mode_e            mode_i,
  input  logic [NUM_PORTS-1:0] set_i,
  input  logic [NUM_PORTS-1:0] clr_i,
  input  logic [NUM_PORTS-1:0] ack_i,
  input  logic [NUM_PORTS-1:0] oc_active_i,
  input  logic [NUM_PORTS-1:0] oc_rise_i,
  output logic [NUM_PORTS-1:0] pwr_o,
  output logic [NUM_PORTS-1:0] change_o,
  output logic [NUM_PORTS-1:0] status_o
);
  localparam logic [NUM_PORTS-1:0] ALL_ON = {NUM_PORTS{1'b1}};

  logic                 gang;
  logic                 any_set, any_clr, any_oc, any_rise;
  logic [NUM_PORTS-1:0] pwr_d, evt, change_d;

  assign gang     = (mode_i == PWR_MODE_GANG);
  assign any_set  = |set_i;
  assign any_clr  = |clr_i;
  assign any_oc   = |oc_active_i;
  assign any_rise = |oc_rise_i;

  always_comb begin
    pwr_d = pwr_o;
    if (!enable_i) begin
      pwr_d = '0;
    end else if (gang) begin
      if (any_rise || any_clr) pwr_d = '0;
      else if (any_set && !any_oc) pwr_d = ALL_ON;
    end else begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (oc_rise_i[i] || clr_i[i]) pwr_d[i] = 1'b0;
        else if (set_i[i] && !oc_active_i[i]) pwr_d[i] = 1'b1;
      end
    end
  end

  always_comb begin
    if (!enable_i) evt = '0;
    else if (gang) evt = {NUM_PORTS{any_rise}};
    else evt = oc_rise_i;
    change_d = (change_o & ~ack_i) | evt;
  end

  assign status_o = gang ? {NUM_PORTS{any_oc}} : oc_active_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_o    <= '0;
      change_o <= '0;
    end else begin
      pwr_o    <= pwr_d;
      change_o <= change_d;
    end
  end

  // R6: in gang mode the ports are never split
  a_r6_gang_together: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && gang) |-> (pwr_o == '0 || pwr_o == ALL_ON));

  // R9: a gang overcurrent leaves nothing powered
  a_r9_gang_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_i && gang && any_rise) |=> (pwr_o == '0));

  generate
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port_chk
      // R8: an accepted event on this port removes its power next cycle
      a_r8_oc_cuts_port: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && oc_rise_i[g]) |=> !pwr_o[g]);
      // R10: power cannot come up while the port's own overcurrent holds
      a_r10_no_power_in_oc: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_active_i[g] && !pwr_o[g]) |=> !pwr_o[g]);
      // R11: the flag only rises from an overcurrent event
      a_r11_change_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(change_o[g]) |-> $past(oc_rise_i != '0));
    end
  endgenerate
endmodule

// File: rtl/port_power_ctl.sv
module port_power_ctl
  import ppc_pkg::*;
#(
  parameter int NUM_PORTS    = 2,
  parameter int STRAP_CYCLES = 72,
  parameter int FILT_CYCLES  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_pad_in,
  input  logic [NUM_PORTS-1:0] pwr_set,
  input  logic [NUM_PORTS-1:0] pwr_clr,
  input  logic [NUM_PORTS-1:0] oc_n,
  input  logic [NUM_PORTS-1:0] oc_ack,
  output logic [NUM_PORTS-1:0] pwr_oe,
  output logic [NUM_PORTS-1:0] port_powered,
  output logic [NUM_PORTS-1:0] oc_status,
  output logic [NUM_PORTS-1:0] oc_change,
  output logic                 gang_mode,
  output logic                 strap_done
);
  pwr_mode_e            mode;
  logic [NUM_PORTS-1:0] oc_active, oc_rise, pwr;

  ppc_strap_latch #(.STRAP_CYCLES(STRAP_CYCLES)) u_strap (
    .clk         (clk),
    .rst_n       (rst_n),
    .pad_level_i (strap_pad_in),
    .done_o      (strap_done),
    .mode_o      (mode)
  );

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_filt
      ppc_oc_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk          (clk),
        .rst_n        (rst_n),
        .oc_n_async_i (oc_n[p]),
        .active_o     (oc_active[p]),
        .rise_o       (oc_rise[p])
      );
    end
  endgenerate

  ppc_power_ctrl #(.NUM_PORTS(NUM_PORTS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (strap_done),
    .mode_i      (mode),
    .set_i       (pwr_set),
    .clr_i       (pwr_clr),
    .ack_i       (oc_ack),
    .oc_active_i (oc_active),
    .oc_rise_i   (oc_rise),
    .pwr_o       (pwr),
    .change_o    (oc_change),
    .status_o    (oc_status)
  );

  assign port_powered = pwr;
  assign pwr_oe       = strap_done ? pwr : '0;
  assign gang_mode    = (mode == PWR_MODE_GANG);

  // R2: the strap pin is never driven inside the window
  a_r2_quiet_before_strap: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_done |-> (pwr_oe == '0));

  // R4: pad enables follow the held power state once driving is allowed
  a_r4_oe_matches: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |-> (pwr_oe == port_powered));
endmodule

// File: tb/sim_port_power_ctl.sv
module sim_port_power_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap_lvl = 2'b11;
  logic       strap_pad_in;
  logic [1:0] pwr_set = '0, pwr_clr = '0, oc_n = 2'b11, oc_ack = '0;
  logic [1:0] pwr_oe, port_powered, oc_status, oc_change;
  logic       gang_mode, strap_done;
  int         n_total = 0, n_fail = 0;
  bit         finished = 0;
  logic [1:0] exp_pwr;

  always #10 clk = ~clk;

  // Open-drain pad: low while enabled, otherwise the strap resistor level
  assign strap_pad_in = pwr_oe[1] ? 1'b0 : strap_lvl[1];

  port_power_ctl u0 (
    .clk(clk), .rst_n(rst_n), .strap_pad_in(strap_pad_in),
    .pwr_set(pwr_set), .pwr_clr(pwr_clr), .oc_n(oc_n), .oc_ack(oc_ack),
    .pwr_oe(pwr_oe), .port_powered(port_powered), .oc_status(oc_status),
    .oc_change(oc_change), .gang_mode(gang_mode), .strap_done(strap_done)
  );

  function automatic logic [1:0] model_pwr(input logic [1:0] cur, s, c,
                                           input logic gang, input logic [1:0] ocs);
    logic [1:0] n = cur;
    if (gang) begin
      if (|c) n = 2'b00;
      else if ((|s) && !(|ocs)) n = 2'b11;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (c[i]) n[i] = 1'b0;
        else if (s[i] && !ocs[i]) n[i] = 1'b1;
      end
    end
    return n;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [1:0] s, input logic [1:0] c, input logic [1:0] a);
    pwr_set = s; pwr_clr = c; oc_ack = a;
    @(posedge clk);
    @(negedge clk);
    pwr_set = '0; pwr_clr = '0; oc_ack = '0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) tick(2'b00, 2'b00, 2'b00);
  endtask

  task automatic do_reset(input logic pad);
    rst_n = 1'b0;
    strap_lvl = {pad, 1'b1};
    oc_n = 2'b11;
    idle(3);
    chk("R3 reset outputs", {pwr_oe, port_powered, oc_status, oc_change, gang_mode, strap_done}, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 71; k++) begin
      if (k == 10) tick(2'b11, 2'b00, 2'b00);
      else tick(2'b00, 2'b00, 2'b00);
    end
    chk("R1 window still open", strap_done, 0);
    chk("R2 no drive in window", pwr_oe, 0);
    tick(2'b00, 2'b00, 2'b00);
    chk("R1 window closes at 72", strap_done, 1);
    chk("R1 mode latched", gang_mode, !pad);
    chk("R2 early set ignored", port_powered, 0);
    exp_pwr = 2'b00;
  endtask

  task automatic random_phase(input int n, input logic gang);
    for (int k = 0; k < n; k++) begin
      logic [1:0] s, c;
      s = 2'(($urandom % 4 == 0) ? $urandom : 0);
      c = 2'(($urandom % 5 == 0) ? $urandom : 0);
      exp_pwr = model_pwr(exp_pwr, s, c, gang, 2'b00);
      tick(s, c, 2'b00);
      chk(gang ? "R6 gang requests" : "R5 individual requests", port_powered, exp_pwr);
      chk("R4 oe follows power", pwr_oe, exp_pwr);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);

    // Individual mode
    do_reset(1'b1);
    random_phase(300, 1'b0);
    tick(2'b11, 2'b00, 2'b00);
    tick(2'b01, 2'b01, 2'b00);
    chk("R5 clear wins over set", port_powered, 2'b10);
    tick(2'b01, 2'b00, 2'b00);
    chk("R5 both powered", port_powered, 2'b11);

    // Glitch of 7 cycles must be filtered out
    oc_n = 2'b10;
    idle(7);
    oc_n = 2'b11;
    idle(15);
    chk("R7 short glitch ignored status", oc_status, 0);
    chk("R7 short glitch keeps power", port_powered, 2'b11);
    chk("R7 short glitch no change", oc_change, 0);

    // Sustained overcurrent on port 0
    oc_n = 2'b10;
    idle(9);
    chk("R7 not yet accepted at edge 9", oc_status, 0);
    idle(1);
    chk("R7 accepted at edge 10", oc_status, 2'b01);
    idle(1);
    chk("R8 only port0 cut", port_powered, 2'b10);
    chk("R8 only change0 set", oc_change, 2'b01);
    tick(2'b01, 2'b00, 2'b00);
    chk("R10 set refused during oc", port_powered, 2'b10);
    oc_n = 2'b11;
    idle(2);
    chk("R7 status held 2 edges after release", oc_status, 2'b01);
    idle(1);
    chk("R7 status clears at edge 3", oc_status, 0);
    tick(2'b00, 2'b00, 2'b10);
    chk("R11 other-bit ack ignored", oc_change, 2'b01);
    tick(2'b00, 2'b00, 2'b01);
    chk("R11 ack clears flag", oc_change, 0);
    tick(2'b01, 2'b00, 2'b00);
    chk("R5 repower after oc", port_powered, 2'b11);

    // Gang mode
    do_reset(1'b0);
    tick(2'b10, 2'b00, 2'b00);
    chk("R6 one set powers both", port_powered, 2'b11);
    tick(2'b00, 2'b01, 2'b00);
    chk("R6 one clear unpowers both", port_powered, 2'b00);
    exp_pwr = 2'b00;
    random_phase(150, 1'b1);
    tick(2'b01, 2'b00, 2'b00);
    oc_n = 2'b01;
    idle(10);
    chk("R9 gang status both", oc_status, 2'b11);
    idle(1);
    chk("R9 gang cut both", port_powered, 2'b00);
    chk("R9 gang change both", oc_change, 2'b11);
    tick(2'b01, 2'b00, 2'b00);
    chk("R10 gang set refused during oc", port_powered, 2'b00);
    oc_n = 2'b11;
    idle(3);
    tick(2'b00, 2'b00, 2'b11);
    chk("R11 gang ack clears", oc_change, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule